// File: doc/BRIEF.md
# Double-Buffered Serial Divider Programming Port

This block is the control-word loader of a frequency synthesizer. A host sends a 20-bit divider word over three wires: data, clock and a load strobe. The word goes into a primary shift register and is copied into a secondary register on the rising edge of the strobe. A bank-select pin picks which of the two registers feeds the decoded divider fields. The host can therefore stage a new setting in the primary register while the counters run from the secondary one, and then switch between the two with a single pin.

A second, 8-bit control word shares the same data and clock wires. It is shifted while the enhancement-write select is high and is captured into a holding register when that select falls. Its bits take effect only while the active-low enhancement-enable pin is low. They drive a power-down flag and a forced counter load flag, and they choose which internal clock, if any, the data-out pin carries.

The serial pins are asynchronous to the system clock. All six control inputs pass through a synchronizer, and edges are detected in the system clock domain before any register changes. The serial link has no back-pressure. The host must hold each serial level for at least SYNC_STAGES+1 system clocks so that every edge is seen.

Top module: `synth_ctrl_loader`

## Requirements
- R1: After reset the primary, secondary and enhancement holding registers are zero, so every field output, both control flags and `dout` are 0.
- R2: While `ewr_sel` and `ld_strobe` are both low, each rising `ser_clk` edge shifts `ser_dat` into the 20-bit primary register, first bit in ending up most significant. With `bank_sel` high, the fields follow the primary register.
- R3: Field layout, from first bit received (word bit 19) to last (bit 0): R[5], R[4], M[8], M[7], prescaler bypass, M[6..0], R[3..0], A[3..0].
- R4: A rising edge of `ld_strobe` copies the primary register into the secondary register. With `bank_sel` low, the fields follow the secondary register, which no other event changes.
- R5: Serial clock edges that arrive while `ld_strobe` is high do not shift either register.
- R6: While `ewr_sel` is high and `ld_strobe` is low, rising `ser_clk` edges shift into an 8-bit enhancement shift register, leaving the primary register untouched. The holding register changes only on the falling edge of `ewr_sel`.
- R7: Control bits act only while `enh_en_n` is low. While it is high, `pwr_down`, `cnt_force_load` and `dout` are 0.
- R8: Control bit k is the k-th bit received (k = 0 first). Bit 3 sets `pwr_down` and bit 4 sets `cnt_force_load`, both active high.
- R9: `dout` carries `fb_div_in` when bit 2 is set, else `mod_sel_in` when bit 5 is set, else `cmp_clk_in` when bit 6 is set, else 0.
- R10: Reserved control bits 0, 1 and 7 have no effect on any output.
- R11: A word longer than 20 bits leaves the last 20 bits received in the primary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock, rising edge shifts |
| ld_strobe | input | 1 | Load strobe; low to shift, rising edge copies primary to secondary |
| ewr_sel | input | 1 | High steers shifting into the control word; falling edge captures it |
| bank_sel | input | 1 | 1 selects the primary register, 0 the secondary |
| enh_en_n | input | 1 | Active-low enable of the control bits |
| fb_div_in | input | 1 | Feedback divider output to be routed to `dout` |
| mod_sel_in | input | 1 | Modulus select to be routed to `dout` |
| cmp_clk_in | input | 1 | Comparison clock to be routed to `dout` |
| ref_div | output | 6 | Reference divider field R |
| main_div | output | 9 | Main counter field M |
| swal_cnt | output | 4 | Modulus-select counter field A |
| pre_bypass | output | 1 | Prescaler bypass bit |
| pwr_down | output | 1 | Power-down flag |
| cnt_force_load | output | 1 | Immediate, continuous counter load flag |
| dout | output | 1 | Routed diagnostic output |

## Verification
A mis-shifted or mis-captured primary register shows up on the field outputs within a few system clocks of the serial edge, but only while `bank_sel` is high. Faults in the secondary register hide until `bank_sel` is low, so the bench reads both banks after every strobe. A wrong control holding register appears on `pwr_down`, `cnt_force_load` or `dout` as soon as `ewr_sel` falls, provided `enh_en_n` is low. `dout` is checked with every combination of its three sources, because a wrong priority only shows when more than one routing bit is set.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned R_W    = 6;
  localparam int unsigned M_W    = 9;
  localparam int unsigned A_W    = 4;
  localparam int unsigned R_HI   = 2;
  localparam int unsigned M_HI   = 2;
  localparam int unsigned ENH_W  = 8;
  localparam int unsigned WORD_W = R_W + M_W + A_W + 1;

  localparam int unsigned POS_R_HI = WORD_W - 1;
  localparam int unsigned POS_M_HI = POS_R_HI - R_HI;
  localparam int unsigned POS_PRE  = POS_M_HI - M_HI;
  localparam int unsigned POS_M_LO = POS_PRE - 1;
  localparam int unsigned POS_R_LO = A_W + (R_W - R_HI) - 1;
  localparam int unsigned POS_A    = A_W - 1;

  // control bit numbers, counted in arrival order
  localparam int unsigned CB_FB   = 2;
  localparam int unsigned CB_PWR  = 3;
  localparam int unsigned CB_LOAD = 4;
  localparam int unsigned CB_MSEL = 5;
  localparam int unsigned CB_CMP  = 6;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           pre;
  } div_fields_t;

  typedef struct packed {
    logic route_fb;
    logic route_ms;
    logic route_cmp;
    logic pwr_dn;
    logic force_ld;
  } ctrl_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned N      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] pipe [0:STAGES];

  for (genvar s = 0; s <= STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/word_shift.sv
module word_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         cap_en,
  output logic [W-1:0] sh,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      hold <= '0;
    end else begin
      if (shift_en) sh <= {sh[W-2:0], bit_in};
      if (cap_en)   hold <= sh;
    end
  end
endmodule

// File: rtl/field_sel.sv
module field_sel
  import synth_cfg_pkg::*;
(
  input  logic [WORD_W-1:0] pri,
  input  logic [WORD_W-1:0] sec,
  input  logic              bank,
  input  logic [ENH_W-1:0]  ehold,
  input  logic              enh_on,
  output div_fields_t       fields,
  output ctrl_t             ctrl
);
  logic [WORD_W-1:0] word;
  logic [ENH_W-1:0]  cbits;
  logic              unused_rsvd;

  assign word = bank ? pri : sec;

  always_comb begin
    fields.r   = {word[POS_R_HI -: R_HI], word[POS_R_LO -: (R_W - R_HI)]};
    fields.m   = {word[POS_M_HI -: M_HI], word[POS_M_LO -: (M_W - M_HI)]};
    fields.a   = word[POS_A -: A_W];
    fields.pre = word[POS_PRE];
  end

  // first bit in sits at the top of the holding register
  for (genvar k = 0; k < ENH_W; k++) begin : g_rev
    assign cbits[k] = ehold[ENH_W-1-k] & enh_on;
  end

  always_comb begin
    ctrl.route_fb  = cbits[CB_FB];
    ctrl.route_ms  = cbits[CB_MSEL];
    ctrl.route_cmp = cbits[CB_CMP];
    ctrl.pwr_dn    = cbits[CB_PWR];
    ctrl.force_ld  = cbits[CB_LOAD];
  end

  assign unused_rsvd = ^{cbits[0], cbits[1], cbits[ENH_W-1]};
endmodule

// File: rtl/route_mux.sv
module route_mux
  import synth_cfg_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  fb_src,
  input  logic  ms_src,
  input  logic  cmp_src,
  output logic  dout
);
  always_comb begin
    if (ctrl.route_fb)       dout = fb_src;
    else if (ctrl.route_ms)  dout = ms_src;
    else if (ctrl.route_cmp) dout = cmp_src;
    else                     dout = 1'b0;
  end
endmodule

// File: rtl/synth_ctrl_loader.sv
module synth_ctrl_loader
  import synth_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_dat,
  input  logic           ser_clk,
  input  logic           ld_strobe,
  input  logic           ewr_sel,
  input  logic           bank_sel,
  input  logic           enh_en_n,
  input  logic           fb_div_in,
  input  logic           mod_sel_in,
  input  logic           cmp_clk_in,
  output logic [R_W-1:0] ref_div,
  output logic [M_W-1:0] main_div,
  output logic [A_W-1:0] swal_cnt,
  output logic           pre_bypass,
  output logic           pwr_down,
  output logic           cnt_force_load,
  output logic           dout
);
  localparam int unsigned I_DAT = 0;
  localparam int unsigned I_CLK = 1;
  localparam int unsigned I_LD  = 2;
  localparam int unsigned I_EWR = 3;
  localparam int unsigned I_BNK = 4;
  localparam int unsigned I_ENH = 5;
  localparam int unsigned N_IN  = 6;

  logic [N_IN-1:0]   raw_in, lvl, rise, fall;
  logic              ld_rise, ewr_fall, ld_lvl, enh_on;
  logic              sh_main, sh_enh;
  logic [WORD_W-1:0] pri_word, sec_word;
  logic [ENH_W-1:0]  enh_sh, ehold;
  div_fields_t       fields;
  ctrl_t             ctrl;
  logic              unused_edges;

  assign raw_in = {enh_en_n, bank_sel, ewr_sel, ld_strobe, ser_clk, ser_dat};

  ctl_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .q(lvl), .rise(rise), .fall(fall)
  );

  assign ld_lvl   = lvl[I_LD];
  assign ld_rise  = rise[I_LD];
  assign ewr_fall = fall[I_EWR];
  assign enh_on   = ~lvl[I_ENH];
  assign sh_main  = rise[I_CLK] & ~ld_lvl & ~lvl[I_EWR];
  assign sh_enh   = rise[I_CLK] & ~ld_lvl &  lvl[I_EWR];

  word_shift #(.W(WORD_W)) u_main (
    .clk(clk), .rst_n(rst_n), .shift_en(sh_main), .bit_in(lvl[I_DAT]),
    .cap_en(ld_rise), .sh(pri_word), .hold(sec_word)
  );

  word_shift #(.W(ENH_W)) u_enh (
    .clk(clk), .rst_n(rst_n), .shift_en(sh_enh), .bit_in(lvl[I_DAT]),
    .cap_en(ewr_fall), .sh(enh_sh), .hold(ehold)
  );

  field_sel u_fsel (
    .pri(pri_word), .sec(sec_word), .bank(lvl[I_BNK]),
    .ehold(ehold), .enh_on(enh_on), .fields(fields), .ctrl(ctrl)
  );

  route_mux u_mux (
    .ctrl(ctrl), .fb_src(fb_div_in), .ms_src(mod_sel_in),
    .cmp_src(cmp_clk_in), .dout(dout)
  );

  assign ref_div        = fields.r;
  assign main_div       = fields.m;
  assign swal_cnt       = fields.a;
  assign pre_bypass     = fields.pre;
  assign pwr_down       = ctrl.pwr_dn;
  assign cnt_force_load = ctrl.force_ld;

  assign unused_edges = ^{rise[I_DAT], rise[I_EWR], rise[I_BNK], rise[I_ENH],
                          fall[I_DAT], fall[I_CLK], fall[I_LD], fall[I_BNK],
                          fall[I_ENH], enh_sh};
endmodule

// File: rtl/synth_ctrl_loader_chk.sv
module synth_ctrl_loader_chk
  import synth_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ld_rise,
  input logic              ld_lvl,
  input logic              ewr_fall,
  input logic              enh_on,
  input logic [WORD_W-1:0] pri_word,
  input logic [WORD_W-1:0] sec_word,
  input logic [ENH_W-1:0]  ehold,
  input logic              pwr_down,
  input logic              cnt_force_load,
  input logic              dout,
  input logic              fb_div_in,
  input logic              mod_sel_in,
  input logic              cmp_clk_in
);
  // R4
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(sec_word));

  // R4
  sec_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> (sec_word == $past(pri_word)));

  // R5
  pri_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lvl |=> $stable(pri_word));

  // R6
  enh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ewr_fall |=> $stable(ehold));

  // R7
  enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_on |-> (!pwr_down && !cnt_force_load && !dout));

  // R9
  dout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> (fb_div_in || mod_sel_in || cmp_clk_in));
endmodule

bind synth_ctrl_loader synth_ctrl_loader_chk u_chk (.*);

// File: tb/sim_synth_ctrl_loader.sv
`timescale 1ns/100ps
module sim_synth_ctrl_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_dat = 0, ser_clk = 0, ld_strobe = 0, ewr_sel = 0;
  logic bank_sel = 1, enh_en_n = 0;
  logic fb_div_in = 0, mod_sel_in = 0, cmp_clk_in = 0;
  logic [5:0] ref_div;
  logic [8:0] main_div;
  logic [3:0] swal_cnt;
  logic pre_bypass, pwr_down, cnt_force_load, dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] pri_m = '0, sec_m = '0;
  logic [7:0]  esh_m = '0, ehold_m = '0;

  always #2 clk = ~clk;

  synth_ctrl_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .ld_strobe(ld_strobe), .ewr_sel(ewr_sel), .bank_sel(bank_sel),
    .enh_en_n(enh_en_n), .fb_div_in(fb_div_in), .mod_sel_in(mod_sel_in),
    .cmp_clk_in(cmp_clk_in), .ref_div(ref_div), .main_div(main_div),
    .swal_cnt(swal_cnt), .pre_bypass(pre_bypass), .pwr_down(pwr_down),
    .cnt_force_load(cnt_force_load), .dout(dout)
  );

  function automatic logic [5:0] f_r(input logic [19:0] w); return {w[19:18], w[7:4]}; endfunction
  function automatic logic [8:0] f_m(input logic [19:0] w); return {w[17:16], w[14:8]}; endfunction
  function automatic logic [3:0] f_a(input logic [19:0] w); return w[3:0]; endfunction
  function automatic logic f_cb(input int k); return ehold_m[7-k] & ~enh_en_n; endfunction
  function automatic logic f_dout();
    if (f_cb(2)) return fb_div_in;
    if (f_cb(5)) return mod_sel_in;
    if (f_cb(6)) return cmp_clk_in;
    return 1'b0;
  endfunction

  task automatic wait_sys(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_fields(input string tag);
    logic [19:0] w;
    w = bank_sel ? pri_m : sec_m;
    chk({tag, " ref_div"},  32'(ref_div),    32'(f_r(w)));
    chk({tag, " main_div"}, 32'(main_div),   32'(f_m(w)));
    chk({tag, " swal_cnt"}, 32'(swal_cnt),   32'(f_a(w)));
    chk({tag, " pre"},      32'(pre_bypass), 32'(w[15]));
  endtask

  task automatic check_ctrl(input string tag);
    chk({tag, " pwr_down"}, 32'(pwr_down),       32'(f_cb(3)));
    chk({tag, " load"},     32'(cnt_force_load), 32'(f_cb(4)));
    chk({tag, " dout"},     32'(dout),           32'(f_dout()));
  endtask

  task automatic clk_bit(input logic b);
    ser_dat = b;   wait_sys(3);
    ser_clk = 1'b1; wait_sys(4);
    ser_clk = 1'b0; wait_sys(3);
    if (!ld_strobe) begin
      if (ewr_sel) esh_m = {esh_m[6:0], b};
      else         pri_m = {pri_m[18:0], b};
    end
  endtask

  task automatic send_main(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(w[i]);
    wait_sys(6);
  endtask

  task automatic strobe();
    ld_strobe = 1'b1; wait_sys(6);
    sec_m = pri_m;
    ld_strobe = 1'b0; wait_sys(6);
  endtask

  task automatic send_enh(input logic [7:0] e);
    ewr_sel = 1'b1; wait_sys(4);
    for (int i = 7; i >= 0; i--) clk_bit(e[i]);
    wait_sys(6);
    check_ctrl("R6 before capture");
    ewr_sel = 1'b0; wait_sys(6);
    ehold_m = esh_m;
  endtask

  task automatic sweep_dout(input string tag);
    for (int s = 0; s < 8; s++) begin
      {fb_div_in, mod_sel_in, cmp_clk_in} = 3'(s);
      #1;
      chk({tag, " dout"}, 32'(dout), 32'(f_dout()));
      wait_sys(1);
    end
    {fb_div_in, mod_sel_in, cmp_clk_in} = 3'b000;
  endtask

  initial begin
    void'($urandom(32'h5EED_0019));
    wait_sys(3);
    rst_n = 1'b1;
    fb_div_in = 1; mod_sel_in = 1; cmp_clk_in = 1;
    wait_sys(6);
    check_fields("R1 reset");
    check_ctrl("R1 reset");
    fb_div_in = 0; mod_sel_in = 0; cmp_clk_in = 0;

    // R3 one-hot walk over every word position
    for (int p = 0; p < 20; p++) begin
      send_main(32'(20'h1 << p), 20);
      check_fields("R3 layout");
    end
    // R2 plain load, first bit most significant
    send_main(32'hA5C3E, 20);
    check_fields("R2 shift");
    chk("R2 msb first", 32'(ref_div), 32'({2'b10, 4'h3}));

    // R4 copy then bank switch
    strobe();
    send_main(32'h1F0F0, 20);
    bank_sel = 1'b0; wait_sys(6);
    check_fields("R4 secondary");
    bank_sel = 1'b1; wait_sys(6);
    check_fields("R4 primary");

    // R5 clocks during a high strobe are ignored
    ld_strobe = 1'b1; wait_sys(6);
    sec_m = pri_m;
    send_main(32'h5A5A5, 20);
    check_fields("R5 frozen");
    ld_strobe = 1'b0; wait_sys(6);
    check_fields("R5 frozen after");

    // R11 overlong word
    send_main(32'hABCDEF1, 28);
    check_fields("R11 last bits");

    // R6 control word leaves primary alone; R8 flags
    send_enh(8'b0001_1000);
    check_fields("R6 primary intact");
    check_ctrl("R8 pwr and load");
    chk("R8 pwr_down set", 32'(pwr_down), 32'd1);

    // R7 gating
    enh_en_n = 1'b1; wait_sys(6);
    check_ctrl("R7 disabled");
    sweep_dout("R7 disabled");
    enh_en_n = 1'b0; wait_sys(6);

    // R9 priorities
    send_enh(8'b0010_0110);  sweep_dout("R9 fb first");
    send_enh(8'b0000_0110);  sweep_dout("R9 ms next");
    send_enh(8'b0000_0010);  sweep_dout("R9 cmp last");
    send_enh(8'b0000_0000);  sweep_dout("R9 none");

    // R10 reserved bits only
    send_enh(8'b1100_0001);
    check_ctrl("R10 reserved");
    sweep_dout("R10 reserved");
    check_fields("R10 reserved");

    // random mix
    for (int it = 0; it < 30; it++) begin
      send_main(32'($urandom()), 20 + int'($urandom_range(0, 3)));
      if ($urandom_range(0, 1) == 1) strobe();
      if ($urandom_range(0, 2) == 0) send_enh(8'($urandom()));
      bank_sel = 1'($urandom());
      enh_en_n = 1'($urandom());
      wait_sys(6);
      check_fields("R2 R4 random");
      check_ctrl("R7 R8 random");
      sweep_dout("R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule